// File: doc/BRIEF.md
# Prescaled Timer with Toggle and PWM Waveform Outputs

This block is a timer that drives two waveform pins. It has a pair of 8-bit counters. They can run as two separate 8-bit units, or they can be chained into one 16-bit counter. A programmable 8-bit prescaler divides the system clock into counting ticks. A 2-bit operating mode decides how the pins behave. In some modes a pin inverts on a period match. In other modes a pin carries a pulse-width-modulated waveform whose duty comes from a compare value. The timer can also count edges on an external input in place of prescaled ticks.

Software programs the block through a simple write port: a strobe, a 3-bit address and a byte of data. All settings are made while the timer is stopped, and then the run bit is set. The block is controlled by a two-state machine. `ST_IDLE` holds the counters at zero, drives both pins low and loads the working copies of the settings. `ST_RUN` counts. The block takes the transition `ST_IDLE -> ST_RUN` when the run bit is set. It takes the transition `ST_RUN -> ST_IDLE` when the run bit is cleared, or when the mode or count-source bit differs from the values latched at start. A changed mode therefore always restarts cleanly. Both pins and both match flags come straight from registers.

Top module: `pwm_toggle_timer`

## Requirements
- R1: After reset, and within three clocks after the run bit is cleared, both waveform pins and both match flags are low.
- R2: The prescaler produces one counting tick every P+1 clocks, where P is the prescale register.
- R3: Mode 0 (split toggle): the low unit counts ticks from 0 up to its period value L. On the tick where it matches L, it restarts at 0 and inverts `wave_a`. The pin therefore inverts every (L+1)*(P+1) clocks.
- R4: Mode 0: the high unit counts either ticks or rising edges of `ext_cnt_in` (ctrl bit 1 set selects edges). After H+1 events it inverts `wave_b`, where H is its period value. Fewer events leave `wave_b` unchanged.
- R5: Mode 1 (dual PWM): each unit counts freely through 256 ticks. Each pin is high while its count is below its compare value C. That gives C*(P+1) high clocks out of every 256*(P+1).
- R6: A compare value of 0 keeps the PWM pin low for the whole period. A compare value of 255 gives 255 high ticks out of 256.
- R7: A compare value written during a PWM period takes effect only from the next period boundary. The period in progress keeps its old duty.
- R8: Mode 2 (16-bit toggle): the chained count runs from 0 to the 16-bit period value and then restarts, inverting `wave_b`. `wave_a` inverts whenever an event finds the low byte equal to the low compare value.
- R9: Mode 3 (16-bit with PWM): `wave_b` toggles as in mode 2, using ticks only. `wave_a` at the same time carries a PWM waveform made from the low byte and the low compare value.
- R10: Register map (write-only). Address 0 is control: bit 0 is run, bit 1 selects external counting, bits 3:2 are the mode. Address 1 is the prescale value. Addresses 2 and 3 are the low and high period values. Addresses 4 and 5 are the low and high compare values.
- R11: `irq_lo` and `irq_hi` are single-clock pulses. Each is raised on the clock where its unit matches or, in PWM use, where it wraps to a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| ext_cnt_in | input | 1 | External count input, synchronised inside |
| wave_a | output | 1 | Low-unit waveform pin |
| wave_b | output | 1 | High-unit waveform pin |
| irq_lo | output | 1 | Low-unit match/wrap pulse |
| irq_hi | output | 1 | High-unit match/wrap pulse |

## Verification
Start latency is not fixed from outside the block. It is a write edge, plus the state change, plus a prescaler phase. For that reason, toggle results are measured as the number of clocks between two successive pin edges, and PWM duty is measured as a count of high clocks over a window exactly one period long. Both measures are independent of phase. Some results do have fixed latency. A stop clears the pins three clocks after the write edge. An external edge lands about three clocks after it is applied, so the bench waits six. In the compare-update test, the window starts at the clock after the observed wrap pulse: 256 samples are taken with the old duty, and the next 256 with the new one. All pins are sampled on the falling clock edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int UNIT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MD_SPLIT  = 2'd0,
        MD_PWM2   = 2'd1,
        MD_TOG16  = 2'd2,
        MD_T16PWM = 2'd3
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] RA_PSC    = 3'd1;
    localparam logic [ADDR_W-1:0] RA_PER_LO = 3'd2;
    localparam logic [ADDR_W-1:0] RA_PER_HI = 3'd3;
    localparam logic [ADDR_W-1:0] RA_CMP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] RA_CMP_HI = 3'd5;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W  = UNIT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic          run,
    output logic          ext_sel,
    output mode_e         mode,
    output logic [W-1:0]  psc,
    output logic [W-1:0]  per_lo,
    output logic [W-1:0]  per_hi,
    output logic [W-1:0]  cmp_lo,
    output logic [W-1:0]  cmp_hi
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            ext_sel <= 1'b0;
            mode    <= MD_SPLIT;
            psc     <= '0;
            per_lo  <= '0;
            per_hi  <= '0;
            cmp_lo  <= '0;
            cmp_hi  <= '0;
        end else if (we) begin
            unique case (addr)
                RA_CTRL: begin
                    run     <= wdata[0];
                    ext_sel <= wdata[1];
                    mode    <= mode_e'(wdata[3:2]);
                end
                RA_PSC:    psc    <= wdata;
                RA_PER_LO: per_lo <= wdata;
                RA_PER_HI: per_hi <= wdata;
                RA_CMP_LO: cmp_lo <= wdata;
                RA_CMP_HI: cmp_hi <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] psc,
    output logic         tick
);
    logic [W-1:0] div_q;

    assign tick = en && (div_q >= psc);

    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (!en)      div_q <= '0;
        else if (tick)     div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // R2: after a tick the next tick is one full divide away unless divide is 1
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || psc == '0));
endmodule

// File: rtl/tmr_extsync.sv
module tmr_extsync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end

    assign rise = sync_q[STAGES-2] & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = UNIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ext_sel,
    input  mode_e        mode,
    input  logic [W-1:0] per_lo,
    input  logic [W-1:0] per_hi,
    input  logic [W-1:0] cmp_lo,
    input  logic [W-1:0] cmp_hi,
    input  logic         tick,
    input  logic         ext_ev,
    output logic         active,
    output logic         wave_a,
    output logic         wave_b,
    output logic         irq_lo,
    output logic         irq_hi
);
    localparam logic [W-1:0] TOP_V = {W{1'b1}};

    state_e         state_q, state_d;
    mode_e          run_mode;
    logic           run_ext;
    logic [W-1:0]   cnt_lo, cnt_hi;
    logic [W-1:0]   act_lo, act_hi;
    logic [2*W-1:0] cnt_w, per_w;
    logic           ev_cnt;

    assign cnt_w  = {cnt_hi, cnt_lo};
    assign per_w  = {per_hi, per_lo};
    assign ev_cnt = run_ext ? ext_ev : tick;
    assign active = (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run) state_d = ST_RUN;
            ST_RUN:  if (!run || mode != run_mode || ext_sel != run_ext)
                         state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_mode <= MD_SPLIT;
            run_ext  <= 1'b0;
            cnt_lo   <= '0;
            cnt_hi   <= '0;
            act_lo   <= '0;
            act_hi   <= '0;
            wave_a   <= 1'b0;
            wave_b   <= 1'b0;
            irq_lo   <= 1'b0;
            irq_hi   <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            run_mode <= mode;
            run_ext  <= ext_sel;
            cnt_lo   <= '0;
            cnt_hi   <= '0;
            act_lo   <= cmp_lo;
            act_hi   <= cmp_hi;
            wave_a   <= 1'b0;
            wave_b   <= 1'b0;
            irq_lo   <= 1'b0;
            irq_hi   <= 1'b0;
        end else begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
            unique case (run_mode)
                MD_SPLIT: begin
                    if (tick) begin
                        if (cnt_lo == per_lo) begin
                            cnt_lo <= '0;
                            wave_a <= ~wave_a;
                            irq_lo <= 1'b1;
                        end else begin
                            cnt_lo <= cnt_lo + 1'b1;
                        end
                    end
                    if (ev_cnt) begin
                        if (cnt_hi == per_hi) begin
                            cnt_hi <= '0;
                            wave_b <= ~wave_b;
                            irq_hi <= 1'b1;
                        end else begin
                            cnt_hi <= cnt_hi + 1'b1;
                        end
                    end
                end
                MD_PWM2: begin
                    wave_a <= (cnt_lo < act_lo);
                    wave_b <= (cnt_hi < act_hi);
                    if (tick) begin
                        cnt_lo <= cnt_lo + 1'b1;
                        cnt_hi <= cnt_hi + 1'b1;
                        if (cnt_lo == TOP_V) begin
                            act_lo <= cmp_lo;
                            irq_lo <= 1'b1;
                        end
                        if (cnt_hi == TOP_V) begin
                            act_hi <= cmp_hi;
                            irq_hi <= 1'b1;
                        end
                    end
                end
                MD_TOG16: begin
                    if (ev_cnt) begin
                        if (cnt_w == per_w) begin
                            {cnt_hi, cnt_lo} <= '0;
                            wave_b <= ~wave_b;
                            irq_hi <= 1'b1;
                        end else begin
                            {cnt_hi, cnt_lo} <= cnt_w + 1'b1;
                        end
                        if (cnt_lo == cmp_lo) begin
                            wave_a <= ~wave_a;
                            irq_lo <= 1'b1;
                        end
                    end
                end
                MD_T16PWM: begin
                    wave_a <= (cnt_lo < act_lo);
                    if (tick) begin
                        if (cnt_w == per_w) begin
                            {cnt_hi, cnt_lo} <= '0;
                            wave_b <= ~wave_b;
                            irq_hi <= 1'b1;
                            act_lo <= cmp_lo;
                            irq_lo <= 1'b1;
                        end else begin
                            {cnt_hi, cnt_lo} <= cnt_w + 1'b1;
                            if (cnt_lo == TOP_V) begin
                                act_lo <= cmp_lo;
                                irq_lo <= 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: a stopped timer drives quiet pins and flags
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (!wave_a && !wave_b && !irq_lo && !irq_hi));

    // R3: in split mode the low pin only moves on a low-unit match
    a_r3_toggle_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && run_mode == MD_SPLIT
         && wave_a != $past(wave_a)) |-> irq_lo);

    // R6: a zero duty leaves the PWM pin low
    a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && (run_mode == MD_PWM2 || run_mode == MD_T16PWM)
         && act_lo == '0) |=> !wave_a);

    // R7: the working duty changes only at a period boundary
    a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN
         && (run_mode == MD_PWM2 || run_mode == MD_T16PWM)
         && act_lo != $past(act_lo)) |-> irq_lo);
endmodule

// File: rtl/pwm_toggle_timer.sv
module pwm_toggle_timer
    import tmr_pkg::*;
#(
    parameter int W  = UNIT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [W-1:0]  cfg_wdata,
    input  logic          ext_cnt_in,
    output logic          wave_a,
    output logic          wave_b,
    output logic          irq_lo,
    output logic          irq_hi
);
    logic         run, ext_sel, tick, ext_ev, active;
    mode_e        mode;
    logic [W-1:0] psc, per_lo, per_hi, cmp_lo, cmp_hi;

    tmr_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .run(run), .ext_sel(ext_sel), .mode(mode), .psc(psc),
        .per_lo(per_lo), .per_hi(per_hi), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi)
    );

    tmr_prescaler #(.W(W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(active), .psc(psc), .tick(tick)
    );

    tmr_extsync #(.STAGES(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_cnt_in), .rise(ext_ev)
    );

    tmr_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .ext_sel(ext_sel), .mode(mode),
        .per_lo(per_lo), .per_hi(per_hi), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .tick(tick), .ext_ev(ext_ev), .active(active),
        .wave_a(wave_a), .wave_b(wave_b), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );
endmodule

// File: tb/sim_pwm_toggle_timer.sv
`timescale 1ns/1ps
module sim_pwm_toggle_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       ext_cnt_in = 1'b0;
    logic       wave_a, wave_b, irq_lo, irq_hi;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pwm_toggle_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ext_cnt_in(ext_cnt_in),
        .wave_a(wave_a), .wave_b(wave_b), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R10: ctrl = {mode[3:2], ext[1], run[0]} at 0; psc 1; per 2/3; cmp 4/5
    task automatic setup(input logic [1:0] md, input logic ext, input logic [7:0] p,
                         input logic [7:0] pl, input logic [7:0] ph,
                         input logic [7:0] cl, input logic [7:0] ch);
        wr(3'd0, 8'h00);
        repeat (3) @(negedge clk);
        wr(3'd1, p); wr(3'd2, pl); wr(3'd3, ph); wr(3'd4, cl); wr(3'd5, ch);
        wr(3'd0, {4'h0, md, ext, 1'b1});
    endtask

    task automatic interval(input bit sel_b, output int n);
        logic p;
        int g;
        g = 0;
        p = sel_b ? wave_b : wave_a;
        while ((sel_b ? wave_b : wave_a) == p && g < 70000) begin @(negedge clk); g++; end
        p = sel_b ? wave_b : wave_a;
        n = 0;
        while ((sel_b ? wave_b : wave_a) == p && n < 70000) begin @(negedge clk); n++; end
    endtask

    task automatic highs(input bit sel_b, input int len, output int h);
        h = 0;
        repeat (len) begin @(negedge clk); h += (sel_b ? wave_b : wave_a); end
    endtask

    task automatic wait_irq_lo();
        int g;
        g = 0;
        while (!irq_lo && g < 70000) begin @(negedge clk); g++; end
    endtask

    task automatic t_reset();
        chk("R1 reset wave_a", wave_a, 0);
        chk("R1 reset wave_b", wave_b, 0);
        chk("R11 reset flags", {irq_lo, irq_hi}, 0);
    endtask

    task automatic t_split_toggle();
        int n;
        setup(2'd0, 1'b0, 8'd2, 8'd9, 8'd4, 8'd0, 8'd0);
        interval(1'b0, n); chk("R3 R2 low toggle interval", n, 30);
        interval(1'b1, n); chk("R4 high tick toggle interval", n, 15);
        setup(2'd0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
        interval(1'b0, n); chk("R3 period zero toggles each clock", n, 1);
    endtask

    task automatic pulse_ext();
        ext_cnt_in = 1'b1; repeat (2) @(negedge clk);
        ext_cnt_in = 1'b0; repeat (3) @(negedge clk);
    endtask

    task automatic t_ext_count();
        logic b0;
        setup(2'd0, 1'b1, 8'd255, 8'd255, 8'd3, 8'd0, 8'd0);
        repeat (5) @(negedge clk);
        b0 = wave_b;
        repeat (3) pulse_ext();
        repeat (6) @(negedge clk);
        chk("R4 three edges leave wave_b", wave_b, b0);
        pulse_ext();
        repeat (6) @(negedge clk);
        chk("R4 fourth edge toggles wave_b", wave_b, !b0);
    endtask

    task automatic t_pwm();
        int h;
        setup(2'd1, 1'b0, 8'd0, 8'd0, 8'd0, 8'h40, 8'hC0);
        repeat (600) @(negedge clk);
        highs(1'b0, 256, h); chk("R5 pwm lane a duty", h, 64);
        highs(1'b1, 256, h); chk("R5 pwm lane b duty", h, 192);
        setup(2'd1, 1'b0, 8'd1, 8'd0, 8'd0, 8'h10, 8'h00);
        repeat (1200) @(negedge clk);
        highs(1'b0, 512, h); chk("R5 R2 prescaled pwm duty", h, 32);
        highs(1'b1, 512, h); chk("R6 compare zero stays low", h, 0);
        setup(2'd1, 1'b0, 8'd0, 8'd0, 8'd0, 8'hFF, 8'h00);
        repeat (600) @(negedge clk);
        highs(1'b0, 256, h); chk("R6 compare 255 duty", h, 255);
    endtask

    task automatic t_cmp_update();
        int h;
        setup(2'd1, 1'b0, 8'd0, 8'd0, 8'd0, 8'h40, 8'h00);
        repeat (600) @(negedge clk);
        wait_irq_lo();
        chk("R11 wrap flag raised", irq_lo, 1);
        wr(3'd4, 8'h20);
        chk("R11 flag lasts one clock", irq_lo, 0);
        h = wave_a;
        repeat (255) begin @(negedge clk); h += wave_a; end
        chk("R7 current period keeps old duty", h, 64);
        highs(1'b0, 256, h); chk("R7 next period uses new duty", h, 32);
    endtask

    task automatic t_wide();
        int n, h;
        setup(2'd2, 1'b0, 8'd1, 8'h05, 8'h01, 8'h80, 8'h00);
        interval(1'b1, n); chk("R8 16-bit toggle interval", n, 524);
        interval(1'b0, n); chk("R8 low byte toggle interval", n, 524);
        setup(2'd3, 1'b0, 8'd0, 8'hFF, 8'h01, 8'h40, 8'h00);
        interval(1'b1, n); chk("R9 16-bit toggle interval", n, 512);
        highs(1'b0, 512, h); chk("R9 low byte pwm duty", h, 128);
    endtask

    task automatic t_stop();
        setup(2'd1, 1'b0, 8'd0, 8'd0, 8'd0, 8'hFF, 8'hFF);
        repeat (40) @(negedge clk);
        wr(3'd0, 8'h04);
        repeat (3) @(negedge clk);
        chk("R1 stop clears pins", {wave_a, wave_b}, 0);
        chk("R1 stop clears flags", {irq_lo, irq_hi}, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_split_toggle();
        t_ext_count();
        t_pwm();
        t_cmp_update();
        t_wide();
        t_stop();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule